// File: doc/BRIEF.md
# SDRAM Bank Address Decoder

The decoder holds one configuration word for each of up to four memory banks. Each word carries the bank's base address, a 3-bit size code and an enable bit. For every physical address that arrives on its input stream, the block finds the bank that claims the address, if any. It returns the bank number, the offset from that bank's base, and a hit flag. A controller-wide enable input gates every bank at once.

Configuration words are written through an indirect register window. The slot for bank i sits at window offset 0x40 + 4*i. Each slot can be read back on a separate combinational read port.

The address stream uses valid/ready on both sides, with a single output register between them:
- An address is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- Its result appears on the output one cycle later.
- `in_ready` is high whenever the output register is empty, or is being emptied in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the output holds its contents and no new address is taken.

Top module: `sdram_bank_decoder`

## Requirements
- R1: After reset every bank word reads as 0. A write to slot 0x40 + 4*i stores the written value ANDed with 0xFFDEE001, and the read port returns that stored value at the same offset.
- R2: A write to any window offset other than the bank slots changes no bank word, and reading such an offset returns 0.
- R3: A bank with base B (word bits 31:23, 8 MiB aligned) and size code c (word bits 19:17, c from 0 to 6) claims an address A exactly when B <= A < B + (4 MiB << c).
- R4: A bank whose enable (word bit 0) is 0 never claims an address.
- R5: While the global enable input is low at the time an address is accepted, that address misses every bank.
- R6: A bank with size code 7 never claims an address.
- R7: When several banks claim one address, the lowest-numbered bank is reported.
- R8: On a hit, `out_bank` is the bank number and `out_offset` is A - B. On a miss, `out_hit` is 0 and both `out_bank` and `out_offset` are 0.
- R9: A result appears with `out_valid` high in the cycle after its address is accepted.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output fields stay unchanged.
- R11: A range that runs to the top of the 32-bit space claims addresses up to 0xFFFFFFFF and does not wrap around to low addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| global_en | input | 1 | Controller-wide enable for all banks |
| wr_en | input | 1 | Register window write strobe |
| wr_off | input | 8 | Register window write offset |
| wr_data | input | 32 | Register window write value |
| rd_off | input | 8 | Register window read offset |
| rd_data | output | 32 | Stored word at rd_off (0 for non-bank offsets) |
| in_valid | input | 1 | Address valid |
| in_ready | output | 1 | Decoder can accept an address |
| in_addr | input | 32 | Physical address to decode |
| out_valid | output | 1 | Decode result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | Some bank claims the address |
| out_bank | output | 2 | Number of the claiming bank |
| out_offset | output | 32 | Address minus the claiming bank's base |

## Verification
The assertions watch the stream on every cycle:
- the one-cycle latency;
- the hold of the output under back-pressure, together with the deasserted `in_ready`;
- zeroed fields on a miss;
- forced misses while the global enable is low.

Only the bench scenarios show the decode itself. That covers range edges, overlap priority, the reserved size code, disabled banks, the top-of-space range and the masked storage of written words. Each of these depends on the programmed bank layout, which a per-cycle property does not see.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  localparam int BASE_LSB      = 23;
  localparam int CODE_LSB      = 17;
  localparam int CODE_W        = 3;
  localparam int EN_BIT        = 0;
  localparam int MIN_SIZE_LOG2 = 22;
  localparam logic [CODE_W-1:0] CODE_RESERVED = 3'd7;
  localparam logic [31:0] STORE_MASK = 32'hFFDE_E001;
  localparam int SLOT_BASE     = 'h40;
  localparam int SLOT_STRIDE   = 4;
endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
  import sdram_dec_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [OFF_W-1:0]                 wr_off,
  input  logic [ADDR_W-1:0]                wr_data,
  input  logic [OFF_W-1:0]                 rd_off,
  output logic [ADDR_W-1:0]                rd_data,
  output logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_word
);
  localparam logic [ADDR_W-1:0] MASK_W = ADDR_W'(STORE_MASK);

  logic [NUM_BANKS-1:0] rd_sel;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_slot
    localparam logic [OFF_W-1:0] SLOT_OFF = OFF_W'(SLOT_BASE + SLOT_STRIDE * i);
    logic [ADDR_W-1:0] word_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wr_en && (wr_off == SLOT_OFF)) begin
        word_q <= wr_data & MASK_W;
      end
    end

    assign bank_word[i] = word_q;
    assign rd_sel[i]    = (rd_off == SLOT_OFF);
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (rd_sel[i]) rd_data = bank_word[i];
    end
  end
endmodule

// File: rtl/bank_window_match.sv
module bank_window_match
  import sdram_dec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] word,
  input  logic              global_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              claim,
  output logic [ADDR_W-1:0] offset
);
  logic [ADDR_W-1:0] base;
  logic [CODE_W-1:0] code;
  logic [ADDR_W:0]   span;
  logic [ADDR_W:0]   limit;
  logic              above_base;
  logic              below_limit;
  logic              usable;

  always_comb begin
    base = '0;
    base[ADDR_W-1:BASE_LSB] = word[ADDR_W-1:BASE_LSB];
    code  = word[CODE_LSB +: CODE_W];
    span  = (ADDR_W+1)'(1) << (MIN_SIZE_LOG2 + int'(code));
    limit = {1'b0, base} + span;
    above_base  = (addr >= base);
    below_limit = ({1'b0, addr} < limit);
    usable = word[EN_BIT] && global_en && (code != CODE_RESERVED);
    claim  = usable && above_base && below_limit;
    offset = addr - base;
  end
endmodule

// File: rtl/lowest_first_pick.sv
module lowest_first_pick #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_BANKS-1:0]             claims,
  input  logic [NUM_BANKS-1:0][ADDR_W-1:0] offsets,
  output logic                             any,
  output logic [IDX_W-1:0]                 idx,
  output logic [ADDR_W-1:0]                offset
);
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    offset = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (claims[i]) begin
        any    = 1'b1;
        idx    = IDX_W'(i);
        offset = offsets[i];
      end
    end
  end
endmodule

// File: rtl/sdram_bank_decoder.sv
module sdram_bank_decoder #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 8,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              global_en,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_bank,
  output logic [ADDR_W-1:0] out_offset
);
  logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_word;
  logic [NUM_BANKS-1:0]             claims;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] offsets;
  logic                             pick_any;
  logic [IDX_W-1:0]                 pick_idx;
  logic [ADDR_W-1:0]                pick_off;
  logic                             accept;

  bank_cfg_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .rd_off(rd_off), .rd_data(rd_data), .bank_word(bank_word)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_match
    bank_window_match #(.ADDR_W(ADDR_W)) u_match (
      .word(bank_word[i]), .global_en(global_en), .addr(in_addr),
      .claim(claims[i]), .offset(offsets[i])
    );
  end

  lowest_first_pick #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pick (
    .claims(claims), .offsets(offsets), .any(pick_any), .idx(pick_idx), .offset(pick_off)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_bank   <= '0;
      out_offset <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_hit    <= pick_any;
      out_bank   <= pick_any ? pick_idx : '0;
      out_offset <= pick_any ? pick_off : '0;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_bank_decoder_chk.sv
module sdram_bank_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              global_en,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hit,
  input logic [IDX_W-1:0]  out_bank,
  input logic [ADDR_W-1:0] out_offset
);
  // R9
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) &&
                                   $stable(out_bank) && $stable(out_offset)));

  // R10
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  miss_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_bank == '0 && out_offset == '0));

  // R5
  global_off_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !global_en) |=> !out_hit);
endmodule

bind sdram_bank_decoder sdram_bank_decoder_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .global_en(global_en), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_hit(out_hit), .out_bank(out_bank), .out_offset(out_offset)
);

// File: tb/sdram_bank_decoder_bench.sv
module sdram_bank_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        global_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_off = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_off = '0;
  logic [31:0] rd_data;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_hit;
  logic [1:0]  out_bank;
  logic [31:0] out_offset;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_bank_decoder u_sdram_bank_decoder (
    .clk(clk), .rst_n(rst_n), .global_en(global_en), .wr_en(wr_en), .wr_off(wr_off),
    .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_bank(out_bank), .out_offset(out_offset)
  );

  // {addr, global_en, hit, bank, offset}
  localparam int NV = 10;
  localparam logic [67:0] VEC [NV] = '{
    {32'h0000_0000, 1'b1, 1'b1, 2'd0, 32'h0000_0000},  // R3 low edge of bank 0
    {32'h00FF_FFFF, 1'b1, 1'b1, 2'd0, 32'h00FF_FFFF},  // R7 overlap, bank 0 wins
    {32'h0100_0000, 1'b1, 1'b1, 2'd1, 32'h0080_0000},  // R3 bank 1 only
    {32'h027F_FFFF, 1'b1, 1'b1, 2'd1, 32'h01FF_FFFF},  // R3 top of bank 1
    {32'h0280_0000, 1'b1, 1'b0, 2'd0, 32'h0000_0000},  // R3 one past bank 1
    {32'h1000_0000, 1'b1, 1'b0, 2'd0, 32'h0000_0000},  // R4 bank 2 disabled
    {32'hFF80_0000, 1'b1, 1'b1, 2'd3, 32'h0000_0000},  // R3 bank 3 base
    {32'hFFFF_FFFF, 1'b1, 1'b1, 2'd3, 32'h007F_FFFF},  // R11 top of space
    {32'hFF7F_FFFF, 1'b1, 1'b0, 2'd0, 32'h0000_0000},  // R3 just below bank 3
    {32'h0000_0010, 1'b0, 1'b0, 2'd0, 32'h0000_0000}   // R5 global enable low
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic write_word(logic [7:0] off, logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_check(string req, logic [7:0] off, logic [31:0] exp);
    @(negedge clk);
    rd_off = off;
    #1 check(req, rd_data, exp);
  endtask

  task automatic decode(string req, logic [31:0] a, logic ge, logic eh, logic [1:0] eb,
                        logic [31:0] eo);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; global_en = ge;
    @(negedge clk);
    in_valid = 1'b0; global_en = 1'b1;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " hit"}, {31'd0, out_hit}, {31'd0, eh});
    check({req, " bank"}, {30'd0, out_bank}, {30'd0, eb});
    check({req, " offset"}, out_offset, eo);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
    for (int i = 0; i < 4; i++) read_check("R1 reset word", 8'(8'h40 + 4 * i), 32'h0);

    // Program the layout
    write_word(8'h40, 32'h0004_0001);  // base 0, 16 MiB
    write_word(8'h44, 32'h0086_0001);  // base 8 MiB, 32 MiB
    write_word(8'h48, 32'h1000_0000);  // base 256 MiB, 4 MiB, disabled
    write_word(8'h4C, 32'hFF8C_0001);  // base 0xFF800000, 256 MiB
    read_check("R1 readback", 8'h44, 32'h0086_0001);

    for (int v = 0; v < NV; v++) begin
      decode("R3/R7/R4/R5/R11 vector", VEC[v][67:36], VEC[v][35], VEC[v][34],
             VEC[v][33:32], VEC[v][31:0]);
    end

    // R1 masking
    write_word(8'h48, 32'hFFFF_FFFF);
    read_check("R1 masked store", 8'h48, 32'hFFDE_E001);
    // R6 bank 2 now has code 7 at base 0xFF800000; bank 3 must win
    decode("R6 reserved code", 32'hFF80_0010, 1'b1, 1'b1, 2'd3, 32'h0000_0010);

    // R2 non-slot write ignored
    write_word(8'h50, 32'hFFFF_FFFF);
    write_word(8'h3C, 32'hFFFF_FFFF);
    read_check("R2 other offset reads 0", 8'h50, 32'h0);
    read_check("R2 bank 0 unchanged", 8'h40, 32'h0004_0001);
    read_check("R2 bank 3 unchanged", 8'h4C, 32'hFF8C_0001);

    // R3 size edge for a 4 MiB bank
    write_word(8'h48, 32'h1000_0001);
    decode("R3 4MiB base", 32'h1000_0000, 1'b1, 1'b1, 2'd2, 32'h0);
    decode("R3 4MiB last", 32'h103F_FFFF, 1'b1, 1'b1, 2'd2, 32'h003F_FFFF);
    decode("R3 4MiB past", 32'h1040_0000, 1'b1, 1'b0, 2'd0, 32'h0);
    // R11 no wrap
    decode("R11 no wrap", 32'h0000_0000, 1'b1, 1'b1, 2'd0, 32'h0);

    // R9 latency and R10 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = 32'h0100_0004;
    check("R9 before edge", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    in_addr = 32'h0000_0008;
    check("R9 after edge", {31'd0, out_valid}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 in_ready low", {31'd0, in_ready}, 32'd0);
      check("R10 bank held", {30'd0, out_bank}, 32'd1);
      check("R10 offset held", out_offset, 32'h0080_0004);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next result", out_offset, 32'h0000_0008);
    check("R7 next bank", {30'd0, out_bank}, 32'd0);
    @(negedge clk);
    check("R9 drains", {31'd0, out_valid}, 32'd0);

    finish_run();
  end
endmodule